// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block gates groups of generated clock outputs. Each group has its own output clock, which is modelled here as a divided copy of a fast reference clock. The group high and low halves each last a parameter-set number of reference cycles. Each group takes an active-low asynchronous stop request. A single active-low power-down input reaches every group. Each output also has a configuration enable bit.

Requests are carried into each group's clock timing by a two-stage synchronizer. This synchronizer advances only at the first reference cycle of a low half, called the low-start strobe. A per-group state machine decides which outputs may pulse. Its states are `GS_RUN` (all outputs pulse), `GS_HALT` (stoppable outputs held low) and `GS_OFF` (every output held low). Its transitions are:
- T_HALT: `GS_RUN` to `GS_HALT`
- T_RESUME: `GS_HALT` to `GS_RUN`
- T_SLEEP: `GS_RUN` or `GS_HALT` to `GS_OFF`
- T_WAKE: `GS_OFF` to `GS_RUN` or `GS_HALT`

The machine moves only at a low-start strobe. Gating therefore changes only while the clock is low, so no shortened high pulse is ever produced. A group may mark output 0 as free-running. That output ignores its group's stop request but still obeys power-down.

Top module: `clkstop_top`

## Requirements
- R1: Group g toggles with a half period of HALF_BASE + g*HALF_STEP reference cycles (defaults 2 and 3). The phase is low after reset and first rises after one half period.
- R2: Every high pulse on every output lasts exactly one full half period. No shortened pulse is ever produced.
- R3: The stop and power-down levels are sampled only at low-start strobes, which fall on the first reference cycle of a low half. A level sampled at strobe k governs the gating from strobe k+2 on. Gating changes only while the phase is low.
- R4: While the synchronized stop of a group is active, every stoppable output of that group is held low.
- R5: An output marked free-running (output 0 of a group whose FREE_MASK bit is 1; by default group 1, flat output bit 3) keeps pulsing while its group is stopped.
- R6: While the synchronized power-down is active, every output of every group is held low, including free-running ones. Power-down overrides stop.
- R7: A stop of one group leaves the outputs of every other group pulsing.
- R8: Enable bit `out_en[g*N_OUT+i]` is sampled at the low-start strobes of group g. A 0 holds output `clk_out[g*N_OUT+i]` low from that strobe on.
- R9: While `rst_n` is low every output is low, and each group starts in `GS_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock from which group clocks are divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down_n | input | 1 | Active-low asynchronous power-down for all groups |
| stop_n | input | N_GROUPS | Active-low asynchronous stop request, one bit per group |
| out_en | input | N_GROUPS*N_OUT | Per-output enable; bit g*N_OUT+i belongs to output i of group g |
| clk_out | output | N_GROUPS*N_OUT | Gated clock outputs, same bit layout as out_en |

## Verification
The bench aims stop, power-down and enable changes at every point of a half period, including the cycles right around a phase edge. A design that gated without waiting for a low phase would emit a short high pulse there, and the pulse-width monitor would catch it. A synchronizer with one stage too few or too many shifts the effect by one strobe, and the per-cycle model comparison reports that as a one-period mismatch. A free-running output that wrongly obeyed stop, or one that ignored power-down, shows up in the window checks, and so does a stop that leaked into the other group.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic [1:0] {
        GS_RUN  = 2'd0,
        GS_HALT = 2'd1,
        GS_OFF  = 2'd2
    } gate_state_t;

    function automatic int half_of(input int base, input int step, input int grp);
        return base + grp * step;
    endfunction

endpackage

// File: rtl/clkstop_divider.sv
module clkstop_divider #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase,
    output logic low_start
);
    localparam int CW = $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign phase     = phase_q;
    assign low_start = !phase_q && (cnt_q == '0);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R1
    AST_PHASE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_q) |-> ($past(cnt_q) == LAST)); // R1

endmodule

// File: rtl/clkstop_sync2.sv
module clkstop_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] first_q;
    logic [W-1:0] second_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q  <= '0;
            second_q <= '0;
        end else if (adv) begin
            first_q  <= d;
            second_q <= first_q;
        end
    end

    assign q = second_q;

    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(second_q)); // R3

endmodule

// File: rtl/clkstop_gate_fsm.sv
module clkstop_gate_fsm
    import clkstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic halt_req,
    input  logic sleep_req,
    output logic gate_grp,
    output logic gate_free
);
    gate_state_t state_q;
    gate_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (adv) begin
            unique case (state_q)
                GS_RUN: begin
                    if (sleep_req)     state_d = GS_OFF;   // T_SLEEP
                    else if (halt_req) state_d = GS_HALT;  // T_HALT
                end
                GS_HALT: begin
                    if (sleep_req)     state_d = GS_OFF;   // T_SLEEP
                    else if (!halt_req) state_d = GS_RUN;  // T_RESUME
                end
                GS_OFF: begin
                    if (!sleep_req)    state_d = halt_req ? GS_HALT : GS_RUN; // T_WAKE
                end
                default:               state_d = GS_RUN;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            GS_RUN:  begin gate_grp = 1'b1; gate_free = 1'b1; end
            GS_HALT: begin gate_grp = 1'b0; gate_free = 1'b1; end
            GS_OFF:  begin gate_grp = 1'b0; gate_free = 1'b0; end
            default: begin gate_grp = 1'b0; gate_free = 1'b0; end
        endcase
    end

    AST_SLEEP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && sleep_req) |=> (state_q == GS_OFF)); // R6
    AST_MOVE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state_q)); // R3

endmodule

// File: rtl/clkstop_group.sv
module clkstop_group #(
    parameter int HALF  = 2,
    parameter int N_OUT = 3,
    parameter bit FREE  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             stop_n,
    input  logic [N_OUT-1:0] en,
    output logic [N_OUT-1:0] clk_o
);
    localparam int HW = $clog2(HALF + 2);

    logic             phase;
    logic             low_start;
    logic [1:0]       req_s;
    logic             gate_grp;
    logic             gate_free;
    logic [N_OUT-1:0] en_q;

    clkstop_divider #(.HALF(HALF)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .low_start (low_start)
    );

    clkstop_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (low_start),
        .d     ({~pd_n, ~stop_n}),
        .q     (req_s)
    );

    clkstop_gate_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (low_start),
        .halt_req  (req_s[0]),
        .sleep_req (req_s[1]),
        .gate_grp  (gate_grp),
        .gate_free (gate_free)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (low_start) begin
            en_q <= en;
        end
    end

    AST_GATE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(gate_grp) || !$stable(gate_free)) |-> !phase); // R3
    AST_EN_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q) |-> !phase); // R8

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        logic [HW-1:0] hi_q;

        if (i == 0 && FREE) begin : g_free
            assign clk_o[i] = phase & en_q[i] & gate_free;
        end else begin : g_stoppable
            assign clk_o[i] = phase & en_q[i] & gate_grp;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_q <= '0;
            end else if (clk_o[i]) begin
                hi_q <= hi_q + 1'b1;
            end else begin
                hi_q <= '0;
            end
        end

        AST_FULL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(clk_o[i]) |-> (hi_q == HW'(HALF))); // R2
    end

endmodule

// File: rtl/clkstop_top.sv
module clkstop_top
    import clkstop_pkg::*;
#(
    parameter int              N_GROUPS  = 2,
    parameter int              N_OUT     = 3,
    parameter int              HALF_BASE = 2,
    parameter int              HALF_STEP = 1,
    parameter logic [N_GROUPS-1:0] FREE_MASK = 2'b10
) (
    input  logic                      clk_ref,
    input  logic                      rst_n,
    input  logic                      pwr_down_n,
    input  logic [N_GROUPS-1:0]       stop_n,
    input  logic [N_GROUPS*N_OUT-1:0] out_en,
    output logic [N_GROUPS*N_OUT-1:0] clk_out
);
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        localparam int HALF_G = half_of(HALF_BASE, HALF_STEP, g);

        clkstop_group #(
            .HALF  (HALF_G),
            .N_OUT (N_OUT),
            .FREE  (FREE_MASK[g])
        ) u_grp (
            .clk    (clk_ref),
            .rst_n  (rst_n),
            .pd_n   (pwr_down_n),
            .stop_n (stop_n[g]),
            .en     (out_en[g*N_OUT +: N_OUT]),
            .clk_o  (clk_out[g*N_OUT +: N_OUT])
        );
    end

    AST_RESET_LOW: assert property (@(posedge clk_ref)
        !rst_n |-> (clk_out == '0)); // R9

endmodule

// File: tb/sim_clkstop_top.sv
module sim_clkstop_top;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 2;
    localparam int NO = 3;
    localparam int NB = NG * NO;
    localparam int HB = 2;
    localparam int HS = 1;
    localparam bit [NG-1:0] FREE = 2'b10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_down_n = 1'b1;
    logic [NG-1:0] stop_n = '1;
    logic [NB-1:0] out_en = '1;
    logic [NB-1:0] clk_out;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_tag  = "R1";
    bit    done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    clkstop_top #(
        .N_GROUPS(NG), .N_OUT(NO), .HALF_BASE(HB), .HALF_STEP(HS), .FREE_MASK(FREE)
    ) u0 (
        .clk_ref(clk), .rst_n(rst_n), .pwr_down_n(pwr_down_n),
        .stop_n(stop_n), .out_en(out_en), .clk_out(clk_out)
    );

    function automatic int half_g(input int g);
        return HB + g * HS;
    endfunction

    // Behavioural reference: divider counts, strobe-sample history, gate state.
    int          mcnt [NG];
    bit          mph  [NG];
    int          mst  [NG];   // 0 run, 1 halted, 2 off
    bit [NO-1:0] men  [NG];
    int          hist [NG][$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) begin
                mcnt[g] = 0; mph[g] = 1'b0; mst[g] = 0; men[g] = '0;
                hist[g].delete();
                hist[g].push_back(3);
                hist[g].push_back(3);
            end
        end else begin
            for (int g = 0; g < NG; g++) begin
                if (!mph[g] && mcnt[g] == 0) begin
                    int code;
                    hist[g].push_back(int'({pwr_down_n, stop_n[g]}));
                    code = hist[g][hist[g].size() - 3];
                    if (code[1] == 1'b0)      mst[g] = 2;
                    else if (code[0] == 1'b0) mst[g] = 1;
                    else                      mst[g] = 0;
                    men[g] = out_en[g*NO +: NO];
                    if (hist[g].size() > 3) void'(hist[g].pop_front());
                end
                if (mcnt[g] == half_g(g) - 1) begin
                    mcnt[g] = 0;
                    mph[g]  = !mph[g];
                end else begin
                    mcnt[g] = mcnt[g] + 1;
                end
            end
        end
    end

    function automatic logic [NB-1:0] model_out();
        logic [NB-1:0] e;
        for (int g = 0; g < NG; g++) begin
            for (int i = 0; i < NO; i++) begin
                bit gate;
                gate = (i == 0 && FREE[g]) ? (mst[g] != 2) : (mst[g] == 0);
                e[g*NO + i] = mph[g] & men[g][i] & gate;
            end
        end
        return e;
    endfunction

    task automatic check(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison, rise counters and pulse-width monitor (R2).
    int rises [NB];
    int hi    [NB];
    bit prev  [NB];

    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_tag, clk_out, model_out());
            for (int k = 0; k < NB; k++) begin
                if (clk_out[k]) begin
                    hi[k]++;
                    if (!prev[k]) rises[k]++;
                end else if (hi[k] > 0) begin
                    check("R2", NB'(hi[k]), NB'(half_g(k / NO)));
                    hi[k] = 0;
                end
                prev[k] = clk_out[k];
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_rises();
        for (int k = 0; k < NB; k++) rises[k] = 0;
    endtask

    task automatic expect_rises(input string tag, input int k, input bit want_some);
        n_checks++;
        if ((rises[k] > 0) != want_some) begin
            n_errors++;
            $display("FAIL %s bit %0d: actual rises=%0d expected %s", tag, k, rises[k],
                     want_some ? "some" : "none");
        end
    endtask

    initial begin
        for (int k = 0; k < NB; k++) begin hi[k] = 0; prev[k] = 0; rises[k] = 0; end
        // R9: outputs low while reset is held
        repeat (4) begin
            @(negedge clk);
            check("R9", clk_out, '0);
        end
        rst_n = 1'b1;

        cur_tag = "R1";
        cycles(20);
        clear_rises();
        cycles(40);
        for (int k = 0; k < NB; k++) expect_rises("R1", k, 1'b1);

        cur_tag = "R4";
        stop_n[0] = 1'b0;
        cycles(30);
        clear_rises();
        cycles(40);
        for (int k = 0; k < NO; k++) expect_rises("R4", k, 1'b0);
        for (int k = NO; k < NB; k++) expect_rises("R7", k, 1'b1);
        stop_n[0] = 1'b1;
        cycles(30);

        cur_tag = "R5";
        stop_n[1] = 1'b0;
        cycles(40);
        clear_rises();
        cycles(40);
        expect_rises("R5", NO, 1'b1);
        expect_rises("R4", NO + 1, 1'b0);
        expect_rises("R4", NO + 2, 1'b0);
        expect_rises("R7", 0, 1'b1);

        cur_tag = "R6";
        pwr_down_n = 1'b0;
        cycles(40);
        clear_rises();
        cycles(40);
        for (int k = 0; k < NB; k++) expect_rises("R6", k, 1'b0);
        pwr_down_n = 1'b1;
        stop_n[1]  = 1'b1;
        cycles(40);
        clear_rises();
        cycles(40);
        for (int k = 0; k < NB; k++) expect_rises("R6", k, 1'b1);

        cur_tag = "R8";
        out_en[1] = 1'b0;
        out_en[NO] = 1'b0;
        cycles(20);
        clear_rises();
        cycles(40);
        expect_rises("R8", 1, 1'b0);
        expect_rises("R8", NO, 1'b0);
        expect_rises("R8", 0, 1'b1);
        out_en = '1;
        cycles(20);

        cur_tag = "R3";
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if ($urandom_range(0, 6) == 0) stop_n[0] = ~stop_n[0];
            if ($urandom_range(0, 8) == 0) stop_n[1] = ~stop_n[1];
            if ($urandom_range(0, 40) == 0) pwr_down_n = ~pwr_down_n;
            if ($urandom_range(0, 25) == 0) out_en[$urandom_range(0, NB - 1)] ^= 1'b1;
        end
        pwr_down_n = 1'b1;
        stop_n = '1;
        out_en = '1;
        cycles(40);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule